// File: doc/BRIEF.md
# Safe-Commutation Gate Pattern Generator

This block drives the four gates of the two bidirectional switches in a single-phase direct AC-AC converter. Each bidirectional switch is a back-to-back pair with a forward leg and a reverse leg. The block takes three inputs: a polarity bit for the line voltage, a two-bit operating mode and a duty compare word. From these it decides which legs stay on for the whole half line cycle, which leg is held off, and which single leg is pulse-width modulated against a free-running carrier.

Two rules keep the commutation safe. The legs that carry current stay asserted while the modulated leg toggles, and the leg that would conduct in the opposite polarity stays off. No complementary pair or dead time is used. A change of polarity, mode or duty is applied only at a carrier wrap. The polarity bit must agree on two consecutive samples before it is accepted, which rejects chatter near a zero crossing.

Top module: `sc_gate_gen`

## Requirements
- R1: While rst_ni is low, gate_o is 4'b0000. After reset, gate_o stays 4'b0000 until the first carrier wrap at which a filtered polarity is available.
- R2: Gate bits are gate_o[0] switch-1 forward, gate_o[1] switch-1 reverse, gate_o[2] switch-2 forward, gate_o[3] switch-2 reverse. With mode_i=2'b01 (in-phase) and pol_pos_i=1, bits 0 and 3 are held at 1, bit 1 is held at 0, and bit 2 is the modulated leg.
- R3: With mode_i=2'b01 and pol_pos_i=0, bits 1 and 2 are held at 1, bit 0 is held at 0, and bit 3 is the modulated leg.
- R4: With mode_i=2'b10 (out-of-phase), pol_pos_i=1 holds bits 1 and 2 at 1 and bit 0 at 0, with bit 3 modulated. pol_pos_i=0 holds bits 0 and 3 at 1 and bit 1 at 0, with bit 2 modulated.
- R5: mode_i=2'b00 (bypass) gives a constant gate_o=4'b1100. The undefined code 2'b11 gives the same pattern.
- R6: The compare value is min(duty_i, PERIOD). The carrier counts 0 to PERIOD-1. The modulated leg is high while the carrier is at or above the compare value, so it is high for PERIOD-compare cycles of each period: always high at 0, never high at PERIOD or above.
- R7: A new duty_i, mode_i or polarity takes effect only at the carrier wrap. The period in progress keeps its old pulse width.
- R8: A polarity input that differs for only one sample does not change the pattern.
- R9: Switch-1 forward and reverse are never on together. Whenever any gate is on, at least one switch-2 leg is on, so a current path always exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pol_pos_i | input | 1 | Line polarity, 1 = positive |
| mode_i | input | 2 | 00 bypass, 01 in-phase, 10 out-of-phase, 11 treated as bypass |
| duty_i | input | DUTY_W | Duty compare value, in carrier counts |
| gate_o | output | 4 | Gate drives {sw2 rev, sw2 fwd, sw1 rev, sw1 fwd} |

## Verification
The assertions assume one thing about the inputs: new mode, polarity or duty values are held long enough to be latched at a wrap. That lets the held switch-1 legs change only in the cycle just after a wrap. Under that assumption, the current-path and exclusion properties hold for any input sequence. The stimulus changes inputs only on falling clock edges and waits more than two carrier periods before it measures. The one exception is a deliberate single-cycle polarity glitch. Every other stimulus keeps the polarity level long enough for the two-sample filter to agree.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_INPH   = 2'b01,
    MODE_OUTPH  = 2'b10
  } sc_mode_e;

  localparam int unsigned G_S1F = 0;
  localparam int unsigned G_S1R = 1;
  localparam int unsigned G_S2F = 2;
  localparam int unsigned G_S2R = 3;
  localparam int unsigned N_GATE = 4;
endpackage

// File: rtl/sc_carrier.sv
module sc_carrier #(
  parameter int unsigned PERIOD = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sc_pol_filter.sv
module sc_pol_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pol_i,
  output logic pol_o,
  output logic valid_o
);
  logic prev_q, prev_v_q, pol_q, val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      prev_v_q <= 1'b0;
      pol_q    <= 1'b0;
      val_q    <= 1'b0;
    end else begin
      prev_q   <= pol_i;
      prev_v_q <= 1'b1;
      // accept only two agreeing samples
      if (prev_v_q && (prev_q == pol_i)) begin
        pol_q <= pol_i;
        val_q <= 1'b1;
      end
    end
  end

  assign pol_o   = pol_q;
  assign valid_o = val_q;
endmodule

// File: rtl/sc_pattern.sv
module sc_pattern
  import sc_pkg::*;
(
  input  logic              valid_i,
  input  logic              pos_i,
  input  logic [1:0]        mode_i,
  input  logic              pwm_i,
  output logic [N_GATE-1:0] gate_o
);
  always_comb begin
    gate_o = '0;
    if (valid_i) begin
      case (mode_i)
        MODE_INPH: begin
          if (pos_i) begin
            gate_o[G_S1F] = 1'b1;
            gate_o[G_S2R] = 1'b1;
            gate_o[G_S2F] = pwm_i;
          end else begin
            gate_o[G_S1R] = 1'b1;
            gate_o[G_S2F] = 1'b1;
            gate_o[G_S2R] = pwm_i;
          end
        end
        MODE_OUTPH: begin
          if (pos_i) begin
            gate_o[G_S1R] = 1'b1;
            gate_o[G_S2F] = 1'b1;
            gate_o[G_S2R] = pwm_i;
          end else begin
            gate_o[G_S1F] = 1'b1;
            gate_o[G_S2R] = 1'b1;
            gate_o[G_S2F] = pwm_i;
          end
        end
        default: begin
          // bypass and undefined codes
          gate_o[G_S2F] = 1'b1;
          gate_o[G_S2R] = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sc_gate_gen.sv
module sc_gate_gen
  import sc_pkg::*;
#(
  parameter int unsigned PERIOD = 16,
  parameter int unsigned DUTY_W = $clog2(PERIOD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pol_pos_i,
  input  logic [1:0]        mode_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [N_GATE-1:0] gate_o
);
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [DUTY_W-1:0] CMP_MAX = DUTY_W'(PERIOD);

  logic [CNT_W-1:0]  cnt_q;
  logic              wrap;
  logic              pol_f, pol_fv;
  logic              act_v_q, act_pos_q;
  logic [1:0]        act_mode_q;
  logic [DUTY_W-1:0] cmp_q, cmp_d, cnt_ext;
  logic              pwm;
  logic [N_GATE-1:0] gate_d, gate_q;

  sc_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  sc_pol_filter u_flt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pol_i   (pol_pos_i),
    .pol_o   (pol_f),
    .valid_o (pol_fv)
  );

  assign cmp_d = (duty_i > CMP_MAX) ? CMP_MAX : duty_i;

  // operating point is only updated at carrier wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_v_q    <= 1'b0;
      act_pos_q  <= 1'b0;
      act_mode_q <= MODE_BYPASS;
      cmp_q      <= CMP_MAX;
    end else if (wrap) begin
      act_v_q    <= pol_fv;
      act_pos_q  <= pol_f;
      act_mode_q <= mode_i;
      cmp_q      <= cmp_d;
    end
  end

  assign cnt_ext = DUTY_W'(cnt_q);
  assign pwm     = (cnt_ext >= cmp_q);

  sc_pattern u_pat (
    .valid_i (act_v_q),
    .pos_i   (act_pos_q),
    .mode_i  (act_mode_q),
    .pwm_i   (pwm),
    .gate_o  (gate_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= gate_d;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/sc_gate_gen_chk.sv
module sc_gate_gen_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       gate_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             act_v_q
);
  // R9
  s1_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[0] && gate_o[1]));

  // R9
  path_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o != 4'b0000) |-> (gate_o[2] || gate_o[3]));

  // R1
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(act_v_q) |-> (gate_o == 4'b0000));

  // R7
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) != '0) |-> $stable(gate_o[1:0]));

  // R5
  legal_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o != 4'b0000) |-> ($countones(gate_o) inside {2, 3}));
endmodule

bind sc_gate_gen sc_gate_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .gate_o  (gate_o),
  .cnt_q   (cnt_q),
  .act_v_q (act_v_q)
);

// File: tb/tb_sc_gate_gen.sv
module tb_sc_gate_gen;
  localparam int PERIOD = 16;
  localparam int DW = 5;
  localparam int NV = 9;

  // {mode, pol, duty, fixed bits, pwm mask, expected width}
  localparam logic [20:0] VEC [NV] = '{
    {2'b01, 1'b1, 5'd4,  4'b1001, 4'b0100, 5'd12},
    {2'b01, 1'b0, 5'd10, 4'b0110, 4'b1000, 5'd6},
    {2'b10, 1'b1, 5'd0,  4'b0110, 4'b1000, 5'd16},
    {2'b10, 1'b0, 5'd16, 4'b1001, 4'b0100, 5'd0},
    {2'b01, 1'b1, 5'd20, 4'b1001, 4'b0100, 5'd0},
    {2'b00, 1'b1, 5'd5,  4'b1100, 4'b0000, 5'd0},
    {2'b11, 1'b0, 5'd3,  4'b1100, 4'b0000, 5'd0},
    {2'b10, 1'b1, 5'd15, 4'b0110, 4'b1000, 5'd1},
    {2'b01, 1'b0, 5'd1,  4'b0110, 4'b1000, 5'd15}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pol_pos_i = 1'b1;
  logic [1:0] mode_i = 2'b01;
  logic [DW-1:0] duty_i = 5'd4;
  logic [3:0] gate_o;

  int checks = 0;
  int errors = 0;
  int bad9 = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sc_gate_gen #(.PERIOD(PERIOD)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pol_pos_i (pol_pos_i),
    .mode_i    (mode_i),
    .duty_i    (duty_i),
    .gate_o    (gate_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R9 monitor
  always @(negedge clk_i)
    if (rst_ni && ((gate_o[0] && gate_o[1]) ||
                   (gate_o != 4'b0000 && !gate_o[2] && !gate_o[3])))
      bad9++;

  task automatic settle();
    repeat (2 * PERIOD + 8) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk_i);
    chk(gate_o == 4'b0000, "R1 during reset", gate_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(gate_o == 4'b0000, "R1 before first wrap", gate_o, 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] m;
      logic p;
      logic [3:0] fixed, pmask;
      int wexp, ones, held_bad;
      string tag;
      m = VEC[v][20:19];
      p = VEC[v][18];
      fixed = VEC[v][12:9];
      pmask = VEC[v][8:5];
      wexp = int'(VEC[v][4:0]);
      mode_i = m;
      pol_pos_i = p;
      duty_i = VEC[v][17:13];
      settle();
      ones = 0;
      held_bad = 0;
      for (int k = 0; k < PERIOD; k++) begin
        @(negedge clk_i);
        if ((gate_o & ~pmask) != fixed) held_bad++;
        if ((gate_o & pmask) != 4'b0000) ones++;
      end
      if (m == 2'b01 && p) tag = "R2";
      else if (m == 2'b01) tag = "R3";
      else if (m == 2'b10) tag = "R4";
      else tag = "R5";
      chk(held_bad == 0, {tag, " held legs"}, held_bad, 0);
      chk(ones == wexp, "R6 pulse width", ones, wexp);
    end

    // R7: duty change mid-period applies at next wrap
    begin
      logic prev;
      int ones_a, ones_b, guard;
      mode_i = 2'b01;
      pol_pos_i = 1'b1;
      duty_i = 5'd8;
      settle();
      prev = gate_o[2];
      guard = 0;
      @(negedge clk_i);
      while (!(prev && !gate_o[2]) && guard < 64) begin
        prev = gate_o[2];
        @(negedge clk_i);
        guard++;
      end
      ones_a = 0;
      for (int k = 0; k < PERIOD; k++) begin
        if (k == 2) duty_i = 5'd2;
        if (gate_o[2]) ones_a++;
        @(negedge clk_i);
      end
      ones_b = 0;
      for (int k = 0; k < PERIOD; k++) begin
        if (gate_o[2]) ones_b++;
        @(negedge clk_i);
      end
      chk(ones_a == 8, "R7 old duty kept in current period", ones_a, 8);
      chk(ones_b == 14, "R7 new duty after wrap", ones_b, 14);
    end

    // R8: single-sample polarity glitch
    begin
      int bad8;
      duty_i = 5'd8;
      settle();
      pol_pos_i = 1'b0;
      @(negedge clk_i);
      pol_pos_i = 1'b1;
      bad8 = 0;
      for (int k = 0; k < 3 * PERIOD; k++) begin
        @(negedge clk_i);
        if (gate_o[1] || !gate_o[0] || !gate_o[3]) bad8++;
      end
      chk(bad8 == 0, "R8 glitch ignored", bad8, 0);
    end

    chk(bad9 == 0, "R9 current path kept", bad9, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule